// File: doc/BRIEF.md
# SMBus Block-Transfer Register Slave

This block is a slave-only SMBus endpoint that fronts a 256-byte register file. It answers one fixed 7-bit bus address and supports exactly two transaction shapes. A block write carries a register pointer, then a byte count, then that many data bytes. A block read carries a register pointer, then a repeated START, then the slave returns a byte count followed by data. SCL and SDA are oversampled on the system clock. SDA is driven only as an open-drain pull-down. SCL is never driven, so the master or other devices may stretch the clock low.

Write data is held in a staging buffer. It reaches the register file only when a STOP closes a frame that delivered exactly the announced number of bytes. Any malformed, short, overlong, abandoned or mis-addressed frame leaves every register as it was. The slave drops a transfer when SCL stays low longer than a programmable number of system clocks. It also goes idle on any STOP, including a STOP that follows a START at once.

Top module: `smb_block_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth clock) only an address byte whose upper 7 bits are 0x2C. The address byte's least significant bit selects the direction: 0 for write, 1 for read. A read address is acknowledged only after a write address and pointer byte in the same transaction. Every other address is not acknowledged, including the general call 0x00, and has no effect on the registers.
- R2: A block write frame is START, 0x58, pointer P, count N, then N data bytes, then STOP. The slave acknowledges every byte. After the STOP, register P+i holds data byte i for i = 0..N-1. All registers read 0x00 after reset.
- R3: A block read frame is START, 0x58, pointer P, repeated START, 0x59. The slave first returns the count byte, whose value equals the RD_LEN parameter. It then returns register P, P+1 and so on, one byte per master acknowledge. Every byte is sent most significant bit first, and the slave stops driving after a master not-acknowledge.
- R4: A count byte of 0 or greater than 32 is not acknowledged. The rest of the frame is ignored and no register changes.
- R5: A write frame that reaches STOP with fewer data bytes than its count changes no register. A data byte beyond the count is not acknowledged, and the frame changes no register.
- R6: The register pointer increments by one per data byte and wraps from 0xFF to 0x00, on both writes and reads.
- R7: If SCL stays low for more than TIMEOUT_CYC system clocks during a transfer, the slave releases SDA and abandons the frame. The abandoned frame changes no register, and the following bytes are not acknowledged until a new START.
- R8: After reset, and after a START followed directly by a STOP, SDA is released and the next frame is served normally.
- R9: SCL low phases stretched up to just below the timeout do not disturb a transfer.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |

## Verification
The bench sweeps block writes across several counts, from 1 up to the 32-byte limit. It then reads every written byte back through block reads and compares the result with an arithmetic model. It pushes at the frame rules. Count 0 and count 33 must be refused; a design that only checked the upper bound, or one that committed eagerly, would corrupt registers there. A short frame and a frame with an extra byte must leave the file untouched; a design that wrote each byte on arrival would fail both. The bench also hits the pointer wrap at 0xFF, which a design with a wider pointer or a saturating pointer would miss. It holds SCL low past the timeout while the slave is driving an acknowledge; a design without the timeout would keep SDA stuck low and would commit the frame. Finally, it checks that the direction bit is honoured at the first address byte, that the general call is ignored, and that a bare START-STOP pair leaves the slave ready.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_DATA,
    ST_TX,
    ST_SKIP
  } smb_state_e;
endpackage

// File: rtl/smb_line_sense.sv
module smb_line_sense #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC-2:0], sda_i};
      scl_d    <= scl_pipe[SYNC-1];
      sda_d    <= sda_pipe[SYNC-1];
    end
  end

  assign scl_o      = scl_pipe[SYNC-1];
  assign sda_o      = sda_pipe[SYNC-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges while SCL is steady high are bus conditions
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/smb_scl_timeout.sv
module smb_scl_timeout #(
  parameter int LIMIT = 3_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic scl_low_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!arm_i || !scl_low_i) cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(LIMIT));

  assert_expire_on_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |-> $past(scl_low_i && arm_i));
endmodule

// File: rtl/smb_stage_commit.sv
module smb_stage_commit #(
  parameter int DEPTH = 32,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [7:0]    push_data_i,
  input  logic          commit_i,
  input  logic [AW-1:0] base_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    buf_q [DEPTH];
  logic [CW-1:0] fill_q, len_q;
  logic [IW-1:0] idx_q;
  logic          busy_q;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i) begin
    if (push_i && fill_q < CW'(DEPTH)) buf_q[fill_q[IW-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      base_q <= '0;
    end else begin
      if (clear_i) fill_q <= '0;
      else if (push_i && fill_q < CW'(DEPTH)) fill_q <= fill_q + 1'b1;
      if (commit_i) begin
        busy_q <= 1'b1;
        len_q  <= fill_q;
        idx_q  <= '0;
        base_q <= base_i;
      end else if (busy_q) begin
        if (CW'(idx_q) == len_q - 1'b1) busy_q <= 1'b0;
        else idx_q <= idx_q + 1'b1;
      end
    end
  end

  // drain one staged byte per clock
  assign wr_en_o   = busy_q;
  assign wr_addr_o = base_q + AW'(idx_q);
  assign wr_data_o = buf_q[idx_q];

  assert_commit_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (fill_q != '0) && (fill_q <= CW'(DEPTH)));
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/smb_block_slave.sv
module smb_block_slave import smb_pkg::*; #(
  parameter logic [6:0] SLV_ADDR    = 7'h2C,
  parameter int         MAX_CNT     = 32,
  parameter int         RD_LEN      = 32,
  parameter int         TIMEOUT_CYC = 3_000_000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int PW = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt, tmo;
  smb_state_e state_q;
  logic [3:0]    bit_q;
  logic [7:0]    sh_q, tx_q, cnt_q, got_q, sent_q;
  logic [PW-1:0] ptr_q;
  logic          ack_q, ack_d, have_cmd_q, oe_q;
  logic [7:0]    rx_byte, rd_data;
  logic          byte_end, rx_state, push, commit;
  logic          wr_en;
  logic [PW-1:0] wr_addr;
  logic [7:0]    wr_data;

  smb_line_sense #(.SYNC(SYNC_STAGES)) u_sense (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  smb_scl_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(state_q != ST_IDLE),
    .scl_low_i(~scl_s), .expired_o(tmo)
  );

  assign rx_byte  = {sh_q[6:0], sda_s};
  assign byte_end = scl_rise && (bit_q == 4'd8);
  assign rx_state = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                    (state_q == ST_CNT)  || (state_q == ST_DATA);
  assign push     = byte_end && (state_q == ST_DATA) && ack_q;
  assign commit   = stop_evt && (state_q == ST_DATA) && (got_q == cnt_q);

  smb_stage_commit #(.DEPTH(MAX_CNT), .AW(PW)) u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start_evt | tmo),
    .push_i(push), .push_data_i(sh_q), .commit_i(commit), .base_i(ptr_q),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  smb_regfile #(.AW(PW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en), .waddr_i(wr_addr),
    .wdata_i(wr_data), .raddr_i(ptr_q), .rdata_o(rd_data)
  );

  // ack verdict, latched on the eighth data clock
  always_comb begin
    case (state_q)
      ST_ADDR: ack_d = (rx_byte[7:1] == SLV_ADDR) && (!rx_byte[0] || have_cmd_q);
      ST_CMD:  ack_d = 1'b1;
      ST_CNT:  ack_d = (rx_byte != 8'd0) && (rx_byte <= 8'(MAX_CNT));
      ST_DATA: ack_d = got_q < cnt_q;
      default: ack_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      cnt_q      <= '0;
      got_q      <= '0;
      sent_q     <= '0;
      ptr_q      <= '0;
      ack_q      <= 1'b0;
      have_cmd_q <= 1'b0;
      oe_q       <= 1'b0;
    end else if (tmo) begin
      state_q    <= ST_IDLE;
      oe_q       <= 1'b0;
      have_cmd_q <= 1'b0;
    end else if (start_evt) begin
      state_q <= ST_ADDR;
      bit_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_evt) begin
      state_q    <= ST_IDLE;
      oe_q       <= 1'b0;
      have_cmd_q <= 1'b0;
    end else if (scl_rise && state_q != ST_IDLE && state_q != ST_SKIP) begin
      if (bit_q != 4'd8) begin
        sh_q  <= rx_byte;
        bit_q <= bit_q + 1'b1;
        if (bit_q == 4'd7) ack_q <= ack_d;
      end else begin
        bit_q <= '0;
        case (state_q)
          ST_ADDR: begin
            if (!ack_q) state_q <= ST_SKIP;
            else if (sh_q[0]) begin
              state_q <= ST_TX;
              tx_q    <= 8'(RD_LEN);
              sent_q  <= '0;
            end else state_q <= ST_CMD;
          end
          ST_CMD: begin
            ptr_q      <= sh_q;
            have_cmd_q <= 1'b1;
            state_q    <= ST_CNT;
          end
          ST_CNT: begin
            if (ack_q) begin
              cnt_q   <= sh_q;
              got_q   <= '0;
              state_q <= ST_DATA;
            end else state_q <= ST_SKIP;
          end
          ST_DATA: begin
            if (ack_q) got_q <= got_q + 1'b1;
            else state_q <= ST_SKIP;
          end
          ST_TX: begin
            if (sda_s) state_q <= ST_SKIP;
            else if (sent_q < 8'(RD_LEN)) begin
              tx_q   <= rd_data;
              ptr_q  <= ptr_q + 1'b1;
              sent_q <= sent_q + 1'b1;
            end else tx_q <= 8'hFF;
          end
          default: ;
        endcase
      end
    end else if (scl_fall) begin
      if (state_q == ST_TX && bit_q != 4'd8) begin
        oe_q <= ~tx_q[7];
        tx_q <= {tx_q[6:0], 1'b1};
      end else if (rx_state && bit_q == 4'd8) begin
        oe_q <= ack_q;
      end else begin
        oe_q <= 1'b0;
      end
    end
  end

  assign sda_oe_o = oe_q;

  assert_drive_low_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> !scl_s);
  assert_addr_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_CMD) |-> ($past(sh_q) == {SLV_ADDR, 1'b0}));
  assert_count_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_DATA) |-> (cnt_q != 8'd0) && (cnt_q <= 8'(MAX_CNT)));
  assert_stop_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_evt && !tmo) |=> (state_q == ST_IDLE) && !sda_oe_o);
endmodule

// File: tb/smb_block_slave_test.sv
module smb_block_slave_test;
  localparam int TO  = 1000;
  localparam int RDL = 8;
  localparam int H   = 15;
  localparam logic [6:0] SA = 7'h2C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni = 1'b0, m_scl = 1'b1, m_low = 1'b0;
  logic oe, sda_line;
  assign sda_line = ~(m_low | oe);

  smb_block_slave #(.RD_LEN(RDL), .TIMEOUT_CYC(TO)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(oe)
  );

  int checks = 0, fails = 0, viol = 0, lo = H;
  bit done = 0;
  logic [7:0] mem [256];
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];
  logic oe_d = 1'b0;

  always @(posedge clk) begin
    if (rst_ni && (oe !== oe_d) && m_scl) viol++;
    oe_d <= oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start;
    m_low = 0; tk(2); m_scl = 1; tk(H); m_low = 1; tk(H); m_scl = 0;
  endtask

  task automatic b_rstart;
    tk(5); m_low = 0; tk(H); m_scl = 1; tk(H); m_low = 1; tk(H); m_scl = 0;
  endtask

  task automatic b_stop;
    tk(5); m_low = 1; tk(H); m_scl = 1; tk(H); m_low = 0; tk(H + 40);
  endtask

  task automatic clk_pulse;
    m_scl = 1; tk(H); m_scl = 0;
  endtask

  task automatic put_bit(input bit b);
    tk(5); m_low = ~b; tk(lo); clk_pulse();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    tk(5); m_low = 0; tk(lo); m_scl = 1; tk(H / 2);
    ack = ~sda_line;
    tk(H - H / 2); m_scl = 0;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tk(5); m_low = 0; tk(lo); m_scl = 1; tk(H / 2);
      b[i] = sda_line;
      tk(H - H / 2); m_scl = 0;
    end
    tk(5); m_low = mack; tk(lo); clk_pulse(); tk(5); m_low = 0;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] r, input logic [7:0] c,
                          input int nd, output logic [63:0] av);
    bit k;
    av = '0;
    b_start();
    wr_byte({a, 1'b0}, k); av[0] = k;
    wr_byte(r, k);         av[1] = k;
    wr_byte(c, k);         av[2] = k;
    for (int i = 0; i < nd; i++) begin
      wr_byte(wbuf[i], k); av[3+i] = k;
    end
    b_stop();
  endtask

  task automatic do_read(input logic [7:0] r, input int nd, output logic [7:0] cg,
                         output logic [2:0] av);
    bit k;
    b_start();
    wr_byte({SA, 1'b0}, k); av[0] = k;
    wr_byte(r, k);          av[1] = k;
    b_rstart();
    wr_byte({SA, 1'b1}, k); av[2] = k;
    rd_byte(1'b1, cg);
    for (int i = 0; i < nd; i++) rd_byte(i != nd - 1, rbuf[i]);
    b_stop();
  endtask

  task automatic model_write(input logic [7:0] r, input int n);
    for (int i = 0; i < n; i++) mem[8'(r + i)] = wbuf[i];
  endtask

  task automatic verify(input logic [7:0] r, input int n, input string req);
    logic [7:0] cg;
    logic [2:0] av;
    for (int o = 0; o < n; o += RDL) begin
      int m;
      m = (n - o < RDL) ? n - o : RDL;
      do_read(8'(r + o), m, cg, av);
      chk(av == 3'b111, req, int'(av), 7);
      chk(cg == 8'(RDL), "R3", int'(cg), RDL);
      for (int j = 0; j < m; j++)
        chk(rbuf[j] == mem[8'(r + o + j)], req, int'(rbuf[j]), int'(mem[8'(r + o + j)]));
    end
  endtask

  function automatic logic [63:0] ones(input int n);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    tk(199000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] av;
    bit k;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    tk(20);
    rst_ni = 1;
    tk(20);
    chk(oe == 1'b0 && sda_line == 1'b1, "R8", int'(oe), 0);
    verify(8'h00, 8, "R2");

    // R1: foreign address, general call, read without pointer
    wbuf[0] = 8'h77;
    do_write(7'h2D, 8'h40, 8'd1, 1, av);
    chk(av[0] == 1'b0, "R1", int'(av[0]), 0);
    do_write(7'h00, 8'h40, 8'd1, 1, av);
    chk(av[0] == 1'b0, "R1", int'(av[0]), 0);
    b_start();
    wr_byte({SA, 1'b1}, k);
    chk(k == 1'b0, "R1", int'(k), 0);
    b_stop();
    verify(8'h40, 1, "R1");

    // R8: bare START-STOP, then a normal frame
    b_start();
    b_stop();
    wbuf[0] = 8'hC3; wbuf[1] = 8'h18;
    do_write(SA, 8'h20, 8'd2, 2, av);
    chk(av == ones(5), "R8", int'(av), int'(ones(5)));
    model_write(8'h20, 2);
    verify(8'h20, 2, "R8");

    // R2: sweep of counts up to the limit
    foreach (wbuf[i]) wbuf[i] = 8'h00;
    for (int s = 0; s < 6; s++) begin
      int c;
      logic [7:0] base;
      case (s)
        0: c = 1;
        1: c = 2;
        2: c = 3;
        3: c = 5;
        4: c = 8;
        default: c = 32;
      endcase
      base = 8'(8'hA0 + c * 3);
      for (int i = 0; i < c; i++) wbuf[i] = 8'(c * 37 + i * 29 + 8'h5B);
      do_write(SA, base, 8'(c), c, av);
      chk(av == ones(3 + c), "R2", int'(av[31:0]), int'(ones(3 + c)));
      model_write(base, c);
      verify(base, c, "R2");
    end

    // R3: bit order
    wbuf[0] = 8'h80; wbuf[1] = 8'h01; wbuf[2] = 8'hA5; wbuf[3] = 8'h3C;
    do_write(SA, 8'h90, 8'd4, 4, av);
    model_write(8'h90, 4);
    verify(8'h90, 4, "R3");

    // R4: count 0 and count 33
    wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
    do_write(SA, 8'h50, 8'd0, 1, av);
    chk(av == 64'h3, "R4", int'(av), 3);
    do_write(SA, 8'h50, 8'd33, 2, av);
    chk(av == 64'h3, "R4", int'(av), 3);
    verify(8'h50, 2, "R4");

    // R5: short frame and overlong frame
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(SA, 8'h48, 8'd3, 2, av);
    chk(av == ones(5), "R5", int'(av), int'(ones(5)));
    verify(8'h48, 3, "R5");
    do_write(SA, 8'h48, 8'd2, 3, av);
    chk(av == 64'h1F, "R5", int'(av), 'h1F);
    verify(8'h48, 3, "R5");

    // R6: pointer wrap
    wbuf[0] = 8'h61; wbuf[1] = 8'h62; wbuf[2] = 8'h63; wbuf[3] = 8'h64;
    do_write(SA, 8'hFE, 8'd4, 4, av);
    chk(av == ones(7), "R6", int'(av), int'(ones(7)));
    model_write(8'hFE, 4);
    verify(8'hFE, 4, "R6");

    // R9: stretched low phases
    lo = 200;
    wbuf[0] = 8'h9A; wbuf[1] = 8'hBC; wbuf[2] = 8'h0F;
    do_write(SA, 8'h70, 8'd3, 3, av);
    lo = H;
    chk(av == ones(6), "R9", int'(av), int'(ones(6)));
    model_write(8'h70, 3);
    verify(8'h70, 3, "R9");

    // R7: SCL held low while the slave acknowledges
    b_start();
    wr_byte({SA, 1'b0}, k);
    wr_byte(8'h60, k);
    for (int i = 7; i >= 0; i--) put_bit(i < 2);
    tk(10);
    chk(oe == 1'b1, "R7", int'(oe), 1);
    tk(TO + 50);
    chk(oe == 1'b0, "R7", int'(oe), 0);
    tk(lo);
    clk_pulse();
    for (int i = 0; i < 3; i++) begin
      wr_byte(8'h55, k);
      chk(k == 1'b0, "R7", int'(k), 0);
    end
    b_stop();
    verify(8'h60, 3, "R7");

    chk(viol == 0, "R10", viol, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule